// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between the integer pipeline of a load/store core and a 32-bit data memory whose address selects whole words. It adds the base register value to the sign-extended immediate offset to form the effective address. From that address it derives a word address for the memory port and the byte offset inside the word. For a store it spreads the source register across the byte lanes and raises the write strobes for the lanes being written. For a load it picks the addressed lane or lanes out of the returned word and extends them to 32 bits, with sign or zero fill.

Byte order is little-endian: byte offset 0 is bits 7:0 of the memory word. The three-bit access code follows the usual load/store encoding. Bits 1:0 give the size: 00 is byte, 01 is halfword, 10 is word and 11 is reserved. Bit 2 requests zero extension on loads. A halfword that is not on a 2-byte boundary, or a word that is not on a 4-byte boundary, raises a misalignment flag. The block only flags this; it does not trap. The whole block is combinational, so the writeback value settles in the same cycle that read data arrives. The strobes, the write data and the result are valid only while the matching operation input is high. The block has no handshake and applies no back-pressure: a caller that stalls holds its inputs steady.

Top module: `lsu_byte_align`

## Requirements
- R1: `mem_addr` equals `base_addr` plus the 12-bit `imm_ofs` sign-extended to 32 bits, wrapping modulo 2^32, with bits 1:0 forced to zero. The byte offset is bits 1:0 of that sum.
- R2: For a well-formed store, `mem_wstrb` is 4'b0001 shifted left by the offset for a byte, 4'b0011 shifted left by 2×offset[1] for a halfword, and 4'b1111 for a word.
- R3: `mem_wdata` repeats bits 7:0 of `store_src` in all four lanes for a byte size, and bits 15:0 in both halves for a halfword size. It carries `store_src` unchanged for word and reserved sizes.
- R4: Access code 000 on a load returns the byte in the offset lane, sign-extended to 32 bits.
- R5: Access code 001 on a load returns lanes {2×offset[1]+1, 2×offset[1]} as a halfword, sign-extended.
- R6: Access codes 100 (byte) and 101 (halfword) on a load zero-extend the selected lanes.
- R7: Access code 010 on a load returns `mem_rdata` unchanged.
- R8: With `op_load` or `op_store` high, a halfword with offset[0]=1 or a word with offset≠0 sets `misaligned`. In that case `mem_wstrb` is 0 and `load_result` is 0.
- R9: `mem_wstrb` is 0 whenever `op_store` is low. `load_result` is 0 whenever `op_load` is low. `misaligned` is 0 when both operation inputs are low.
- R10: Size code 11 never raises a strobe, returns a load result of 0, and does not set `misaligned`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_load | input | 1 | Current access is a load |
| op_store | input | 1 | Current access is a store |
| funct3 | input | 3 | Access code: bits 1:0 size, bit 2 unsigned load |
| base_addr | input | 32 | Base register value |
| imm_ofs | input | 12 | Signed immediate offset |
| store_src | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word returned by memory |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_wstrb | output | 4 | Per-byte write strobes |
| load_result | output | 32 | Extended writeback value |
| misaligned | output | 1 | Access violates its natural alignment |

## Verification
The hardest case to reach is an effective address whose low bits differ from those of the base register. A negative immediate can borrow across the word boundary, and an all-ones base can wrap to zero. A design that takes its lanes or alignment from the base alone would then still pick plausible lanes. The stimulus pairs bases ending in 00 with offsets such as -2 and +3, and pairs base 0xFFFFFFFF with +1. Read data is also chosen with 0x7F and 0x80 bytes next to each other, so that sign and zero fill differ on every extended bit.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  function automatic acc_size_e size_of(input logic [2:0] code);
    return acc_size_e'(code[1:0]);
  endfunction
endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int OFS_W = 2
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  word_addr,
  output logic [OFS_W-1:0] byte_ofs
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] eff;

  assign imm_sx    = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign eff       = base + imm_sx;
  assign word_addr = {eff[XLEN-1:OFS_W], {OFS_W{1'b0}}};
  assign byte_ofs  = eff[OFS_W-1:0];
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = XLEN / 8,
  parameter int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  input  logic             op_any,
  input  logic             op_store,
  input  logic [XLEN-1:0]  src,
  output logic [XLEN-1:0]  wdata,
  output logic [LANES-1:0] wstrb,
  output logic             misaligned
);
  logic             raw_mis;
  logic             wr_ok;
  logic [LANES-1:0] lane_hit;

  always_comb begin
    unique case (size)
      SZ_HALF: raw_mis = ofs[0];
      SZ_WORD: raw_mis = (ofs != '0);
      default: raw_mis = 1'b0;
    endcase
  end

  assign misaligned = op_any & raw_mis;
  assign wr_ok      = op_store & ~raw_mis & (size != SZ_RSVD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(i);
    localparam logic [OFS_W-1:0] PAIR_IDX = OFS_W'(i / 2);

    always_comb begin
      unique case (size)
        SZ_BYTE: lane_hit[i] = (ofs == LANE_IDX);
        SZ_HALF: lane_hit[i] = ((ofs >> 1) == PAIR_IDX);
        default: lane_hit[i] = 1'b1;
      endcase
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: wdata[i*8 +: 8] = src[7:0];
        SZ_HALF: wdata[i*8 +: 8] = src[(i % 2)*8 +: 8];
        default: wdata[i*8 +: 8] = src[i*8 +: 8];
      endcase
    end

    assign wstrb[i] = wr_ok & lane_hit[i];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = XLEN / 8,
  parameter int OFS_W = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic             zext,
  input  logic             enable,
  input  logic [OFS_W-1:0] ofs,
  input  logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  result
);
  logic [7:0]       b_sel;
  logic [15:0]      h_sel;
  logic [OFS_W-1:0] h_base;
  logic             fill;

  assign h_base = {ofs[OFS_W-1:1], 1'b0};
  assign b_sel  = rdata[ofs*8 +: 8];
  assign h_sel  = rdata[h_base*8 +: 16];

  always_comb begin
    fill   = 1'b0;
    result = '0;
    if (enable) begin
      unique case (size)
        SZ_BYTE: begin
          fill   = ~zext & b_sel[7];
          result = {{(XLEN-8){fill}}, b_sel};
        end
        SZ_HALF: begin
          fill   = ~zext & h_sel[15];
          result = {{(XLEN-16){fill}}, h_sel};
        end
        SZ_WORD: result = rdata;
        default: result = '0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_byte_align.sv
module lsu_byte_align
  import lsu_align_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int LANES = XLEN / 8,
  parameter int OFS_W = $clog2(LANES)
) (
  input  logic             op_load,
  input  logic             op_store,
  input  logic [2:0]       funct3,
  input  logic [XLEN-1:0]  base_addr,
  input  logic [IMM_W-1:0] imm_ofs,
  input  logic [XLEN-1:0]  store_src,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [LANES-1:0] mem_wstrb,
  output logic [XLEN-1:0]  load_result,
  output logic             misaligned
);
  acc_size_e        size;
  logic [OFS_W-1:0] ofs;

  assign size = size_of(funct3);

  lsu_ea_adder #(.XLEN(XLEN), .IMM_W(IMM_W), .OFS_W(OFS_W)) u_ea (
    .base      (base_addr),
    .imm       (imm_ofs),
    .word_addr (mem_addr),
    .byte_ofs  (ofs)
  );

  lsu_store_lane #(.XLEN(XLEN), .LANES(LANES), .OFS_W(OFS_W)) u_st (
    .size       (size),
    .ofs        (ofs),
    .op_any     (op_load | op_store),
    .op_store   (op_store),
    .src        (store_src),
    .wdata      (mem_wdata),
    .wstrb      (mem_wstrb),
    .misaligned (misaligned)
  );

  lsu_load_extract #(.XLEN(XLEN), .LANES(LANES), .OFS_W(OFS_W)) u_ld (
    .size   (size),
    .zext   (funct3[2]),
    .enable (op_load & ~misaligned),
    .ofs    (ofs),
    .rdata  (mem_rdata),
    .result (load_result)
  );
endmodule

// File: rtl/lsu_byte_align_chk.sv
module lsu_byte_align_chk #(
  parameter int XLEN  = 32,
  parameter int LANES = XLEN / 8
) (
  input logic             op_load,
  input logic             op_store,
  input logic [2:0]       funct3,
  input logic [XLEN-1:0]  mem_addr,
  input logic [LANES-1:0] mem_wstrb,
  input logic [XLEN-1:0]  load_result,
  input logic             misaligned
);
  always_comb begin
    // R1: the memory port never sees a sub-word address
    a_r1_word_addr: assert (mem_addr[1:0] == 2'b00);
    // R2: strobes cover one, two or four lanes only
    a_r2_lane_count: assert (mem_wstrb == '0 || $countones(mem_wstrb) == 1 ||
                             $countones(mem_wstrb) == 2 || $countones(mem_wstrb) == LANES);
    // R8: a flagged access writes nothing
    a_r8_no_write_when_mis: assert (!misaligned || mem_wstrb == '0);
    // R9: strobes only during a store
    a_r9_store_only: assert (op_store || mem_wstrb == '0);
    // R4: signed byte load fills upper bits with bit 7
    a_r4_byte_sign: assert (!(op_load && funct3 == 3'b000 && !misaligned) ||
                            load_result[XLEN-1:8] == {(XLEN-8){load_result[7]}});
    // R6: unsigned halfword load leaves upper bits clear
    a_r6_half_zero: assert (!(op_load && funct3 == 3'b101) ||
                            load_result[XLEN-1:16] == '0);
  end
endmodule

bind lsu_byte_align lsu_byte_align_chk #(.XLEN(XLEN), .LANES(LANES)) u_chk (
  .op_load     (op_load),
  .op_store    (op_store),
  .funct3      (funct3),
  .mem_addr    (mem_addr),
  .mem_wstrb   (mem_wstrb),
  .load_result (load_result),
  .misaligned  (misaligned)
);

// File: tb/lsu_byte_align_tb.sv
module lsu_byte_align_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] S = 32'h1234_56C7;
  localparam logic [31:0] D = 32'h8877_66BB;

  typedef struct packed {
    logic        ld;
    logic        st;
    logic [2:0]  f3;
    logic [31:0] base;
    logic [11:0] imm;
    logic [31:0] src;
    logic [31:0] rdata;
    logic [31:0] e_addr;
    logic [31:0] e_wdata;
    logic [3:0]  e_strb;
    logic [31:0] e_res;
    logic        e_mis;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R2 R3 byte store to lane 3
    '{1'b0,1'b1,3'b000,32'h1000,12'h003,S,D,32'h1000,32'hC7C7C7C7,4'b1000,32'h0,1'b0},
    // R1 negative offset borrows into the previous word; halfword in the upper half
    '{1'b0,1'b1,3'b001,32'h2000,12'hFFE,S,D,32'h1FFC,32'h56C756C7,4'b1100,32'h0,1'b0},
    '{1'b0,1'b1,3'b010,32'h0100,12'h004,S,D,32'h0104,32'h123456C7,4'b1111,32'h0,1'b0},
    // R8 misaligned halfword and word stores
    '{1'b0,1'b1,3'b001,32'h0100,12'h001,S,D,32'h0100,32'h56C756C7,4'b0000,32'h0,1'b1},
    '{1'b0,1'b1,3'b010,32'h0100,12'h002,S,D,32'h0100,32'h123456C7,4'b0000,32'h0,1'b1},
    // R4 signed byte loads, positive and negative
    '{1'b1,1'b0,3'b000,32'h3000,12'h001,S,D,32'h3000,32'hC7C7C7C7,4'b0000,32'h00000066,1'b0},
    '{1'b1,1'b0,3'b000,32'h3000,12'h003,S,D,32'h3000,32'hC7C7C7C7,4'b0000,32'hFFFFFF88,1'b0},
    // R5 signed halfword loads
    '{1'b1,1'b0,3'b001,32'h3000,12'h000,S,D,32'h3000,32'h56C756C7,4'b0000,32'h000066BB,1'b0},
    '{1'b1,1'b0,3'b001,32'h3000,12'h002,S,D,32'h3000,32'h56C756C7,4'b0000,32'hFFFF8877,1'b0},
    // R6 unsigned loads
    '{1'b1,1'b0,3'b100,32'h3000,12'h000,S,D,32'h3000,32'hC7C7C7C7,4'b0000,32'h000000BB,1'b0},
    '{1'b1,1'b0,3'b101,32'h3000,12'h002,S,D,32'h3000,32'h56C756C7,4'b0000,32'h00008877,1'b0},
    // R7 word load at largest positive offset
    '{1'b1,1'b0,3'b010,32'h3000,12'h7FC,S,D,32'h37FC,32'h123456C7,4'b0000,32'h887766BB,1'b0},
    // R8 misaligned halfword load
    '{1'b1,1'b0,3'b001,32'h3000,12'h003,S,D,32'h3000,32'h56C756C7,4'b0000,32'h0,1'b1},
    // R10 reserved size on a store
    '{1'b0,1'b1,3'b011,32'h0040,12'h000,S,D,32'h0040,32'h123456C7,4'b0000,32'h0,1'b0},
    // R9 no operation: nothing flagged, written or returned
    '{1'b0,1'b0,3'b000,32'h0010,12'h001,S,D,32'h0010,32'hC7C7C7C7,4'b0000,32'h0,1'b0},
    // R1 address wraps to zero
    '{1'b0,1'b1,3'b000,32'hFFFFFFFF,12'h001,S,D,32'h0000,32'hC7C7C7C7,4'b0001,32'h0,1'b0}
  };

  logic        clk = 1'b0;
  logic        op_load, op_store, misaligned;
  logic [2:0]  funct3;
  logic [31:0] base_addr, store_src, mem_rdata, mem_addr, mem_wdata, load_result;
  logic [11:0] imm_ofs;
  logic [3:0]  mem_wstrb;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_byte_align u_dut (
    .op_load(op_load), .op_store(op_store), .funct3(funct3),
    .base_addr(base_addr), .imm_ofs(imm_ofs), .store_src(store_src),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wstrb(mem_wstrb), .load_result(load_result), .misaligned(misaligned)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic ld, input logic st, input logic [2:0] f3,
                       input logic [31:0] b, input logic [11:0] im,
                       input logic [31:0] s, input logic [31:0] rd);
    @(negedge clk);
    op_load = ld; op_store = st; funct3 = f3;
    base_addr = b; imm_ofs = im; store_src = s; mem_rdata = rd;
    #1;
  endtask

  function automatic string res_tag(input logic [2:0] f3, input logic mis);
    if (mis)               return "R8";
    if (f3[1:0] == 2'b11)  return "R10";
    if (f3 == 3'b000)      return "R4";
    if (f3 == 3'b001)      return "R5";
    if (f3 == 3'b010)      return "R7";
    return "R6";
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    // Idle state: R9
    apply(1'b0, 1'b0, 3'b000, 32'h0, 12'h0, 32'h0, 32'h0);
    check("R9", "idle strobes", {28'h0, mem_wstrb}, 32'h0);
    check("R9", "idle result", load_result, 32'h0);
    check("R9", "idle flag", {31'h0, misaligned}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].ld, VEC[i].st, VEC[i].f3, VEC[i].base, VEC[i].imm,
            VEC[i].src, VEC[i].rdata);
      check("R1", $sformatf("vec %0d addr", i), mem_addr, VEC[i].e_addr);
      check("R3", $sformatf("vec %0d wdata", i), mem_wdata, VEC[i].e_wdata);
      check(VEC[i].e_mis ? "R8" : (VEC[i].st ? "R2" : "R9"),
            $sformatf("vec %0d strobes", i), {28'h0, mem_wstrb}, {28'h0, VEC[i].e_strb});
      check(res_tag(VEC[i].f3, VEC[i].e_mis), $sformatf("vec %0d result", i),
            load_result, VEC[i].e_res);
      check("R8", $sformatf("vec %0d flag", i), {31'h0, misaligned}, {31'h0, VEC[i].e_mis});
    end

    // R2 R3: byte store walked over every lane
    for (int k = 0; k < 4; k++) begin
      apply(1'b0, 1'b1, 3'b000, 32'h500 + k, 12'h0, 32'hFFFF_FFA5, 32'h0);
      check("R2", $sformatf("byte lane %0d strobe", k), {28'h0, mem_wstrb}, 32'h1 << k);
      check("R3", $sformatf("byte lane %0d data", k), mem_wdata, 32'hA5A5A5A5);
    end

    // R4 R6: sign boundary between 0x7F and 0x80
    apply(1'b1, 1'b0, 3'b000, 32'h600, 12'h0, 32'h0, 32'h0000_807F);
    check("R4", "lb 0x7F", load_result, 32'h0000007F);
    apply(1'b1, 1'b0, 3'b000, 32'h600, 12'h1, 32'h0, 32'h0000_807F);
    check("R4", "lb 0x80", load_result, 32'hFFFFFF80);
    apply(1'b1, 1'b0, 3'b100, 32'h600, 12'h1, 32'h0, 32'h0000_807F);
    check("R6", "lbu 0x80", load_result, 32'h00000080);

    // R9: word load raises no strobe; R10 reserved-size load returns zero
    apply(1'b1, 1'b0, 3'b010, 32'h700, 12'h0, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    check("R9", "load strobes", {28'h0, mem_wstrb}, 32'h0);
    apply(1'b1, 1'b0, 3'b111, 32'h700, 12'h0, 32'h0, 32'hDEAD_BEEF);
    check("R10", "reserved load result", load_result, 32'h0);
    check("R10", "reserved load flag", {31'h0, misaligned}, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule